// File: doc/BRIEF.md
# Shift-Based Single-Pole Lowpass Smoother

This block smooths a stream of signed samples with a first-order recursive lowpass. Each time a sample is accepted, the stored value moves toward the new sample by one 2^SHIFT-th of the gap between them. The division is an arithmetic right shift, so there is no multiplier and no divider. The effective time constant is 2^SHIFT sample periods, which puts the corner near 1/(2·pi·T·2^SHIFT) for a sample period T.

The state carries SHIFT fractional bits beyond the DATA_W-bit input, so the recursion drops no precision. The bench and the assertions treat the state as a signed number in units of input LSB / 2^SHIFT. Two views of the result are available: the full-precision state, and a DATA_W-bit value rounded half-up and limited to the most positive DATA_W-bit code. A synchronous reset and a separate synchronous clear both return the state to zero.

Top module: `lpf_shift_iir`

## Requirements
- R1: While `rst` is high at a clock edge, `filtState` becomes zero and `filtValid` becomes low.
- R2: At an edge with `sampleValid` high and `clrIn` low, the state becomes s + floor(((x·2^SHIFT) − s) / 2^SHIFT). Here s is the signed state, x is the signed `sampleIn`, and the division is a two's-complement arithmetic right shift (it rounds toward minus infinity).
- R3: At an edge with `sampleValid` and `clrIn` both low, the state keeps its value.
- R4: `filtValid` is high in exactly the cycle after an edge at which a sample was accepted (`sampleValid` high, `clrIn` low, `rst` low), and low otherwise.
- R5: At an edge with `clrIn` high, the state becomes zero and `filtValid` is low in the next cycle. This holds even when `sampleValid` is high at the same edge, and that sample is discarded.
- R6: `filtOut` equals floor((s + 2^(SHIFT−1)) / 2^SHIFT), so exact halves round toward plus infinity. A result above 2^(DATA_W−1)−1 is limited to that value.
- R7: Starting from a zero state, the first accepted sample x leaves the state equal to x, which is 1/2^SHIFT of the step expressed in state units.
- R8: The state always stays between −2^(DATA_W−1)·2^SHIFT and (2^(DATA_W−1)−1)·2^SHIFT. Holding the most positive input never makes `filtOut` wrap negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clrIn | input | 1 | Synchronous clear of the filter state |
| sampleValid | input | 1 | Marks `sampleIn` as a new sample |
| sampleIn | input | DATA_W | Signed input sample |
| filtValid | output | 1 | High the cycle after a sample is accepted |
| filtState | output | DATA_W+SHIFT | Signed full-precision state |
| filtOut | output | DATA_W | Rounded, saturated output |

## Verification
A clear and a valid sample can arrive at the same edge. The clear must win: the sample is discarded and no valid strobe follows. The bench provokes this collision both in a directed step and at random points inside a long random stream. After each collision it judges the zero state, the low `filtValid`, and the next accepted sample, which must behave as the first step from zero.

// File: rtl/lpf_shift_pkg.sv
package lpf_shift_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic clear;   // force the state to zero
    logic load;    // apply one recursion step
  } lpfCtrl_t;

endpackage

// File: rtl/lpf_shift_ctrl.sv
module lpf_shift_ctrl
  import lpf_shift_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clrIn,
  input  logic     sampleValid,
  output lpfCtrl_t ctrl,
  output logic     filtValid
);

  // A clear outranks a sample arriving at the same edge.
  always_comb begin
    ctrl.clear = clrIn;
    ctrl.load  = sampleValid && !clrIn;
  end

  always_ff @(posedge clk) begin
    if (rst) filtValid <= 1'b0;
    else     filtValid <= ctrl.load;
  end

endmodule

// File: rtl/lpf_shift_datapath.sv
module lpf_shift_datapath
  import lpf_shift_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SHIFT  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  lpfCtrl_t                   ctrl,
  input  logic [DATA_W-1:0]          sampleIn,
  output logic [DATA_W+SHIFT-1:0]    filtState,
  output logic [DATA_W-1:0]          filtOut
);

  localparam int STATE_W = DATA_W + SHIFT;
  localparam int SUM_W   = STATE_W + 1;   // one guard bit
  localparam logic [SUM_W-1:0] HALF_LSB = {{(SUM_W-1){1'b0}}, 1'b1} << (SHIFT-1);
  localparam logic [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};

  logic        [STATE_W-1:0] stateQ;
  logic signed [SUM_W-1:0]   stateExt;
  logic signed [SUM_W-1:0]   inScaled;
  logic signed [SUM_W-1:0]   gap;
  logic signed [SUM_W-1:0]   step;
  logic signed [SUM_W-1:0]   nextSum;
  logic signed [SUM_W-1:0]   roundSum;
  logic        [DATA_W:0]    roundQ;
  logic                      overTop;

  // Align the input with the state: sign-extend by one, append SHIFT zeros.
  always_comb begin
    stateExt = $signed({stateQ[STATE_W-1], stateQ});
    inScaled = $signed({sampleIn[DATA_W-1], sampleIn, {SHIFT{1'b0}}});
    gap      = inScaled - stateExt;
    step     = gap >>> SHIFT;
    nextSum  = stateExt + step;
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) stateQ <= '0;
    else if (ctrl.load)    stateQ <= nextSum[STATE_W-1:0];
  end

  // Half-up rounding of the top bits, limited at the positive extreme.
  always_comb begin
    roundSum = stateExt + $signed(HALF_LSB);
    roundQ   = roundSum[SUM_W-1:SHIFT];
    overTop  = !roundQ[DATA_W] && roundQ[DATA_W-1];
    filtOut  = overTop ? OUT_MAX : roundQ[DATA_W-1:0];
  end

  assign filtState = stateQ;

endmodule

// File: rtl/lpf_shift_iir.sv
module lpf_shift_iir
  import lpf_shift_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SHIFT  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clrIn,
  input  logic                    sampleValid,
  input  logic [DATA_W-1:0]       sampleIn,
  output logic                    filtValid,
  output logic [DATA_W+SHIFT-1:0] filtState,
  output logic [DATA_W-1:0]       filtOut
);

  lpfCtrl_t ctrl;

  lpf_shift_ctrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .clrIn       (clrIn),
    .sampleValid (sampleValid),
    .ctrl        (ctrl),
    .filtValid   (filtValid)
  );

  lpf_shift_datapath #(.DATA_W(DATA_W), .SHIFT(SHIFT)) uPath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .sampleIn  (sampleIn),
    .filtState (filtState),
    .filtOut   (filtOut)
  );

endmodule

// File: rtl/lpf_shift_iir_chk.sv
module lpf_shift_iir_chk #(
  parameter int DATA_W = 12,
  parameter int SHIFT  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clrIn,
  input logic                    sampleValid,
  input logic [DATA_W-1:0]       sampleIn,
  input logic                    filtValid,
  input logic [DATA_W+SHIFT-1:0] filtState,
  input logic [DATA_W-1:0]       filtOut
);

  localparam int STATE_W = DATA_W + SHIFT;
  localparam longint ST_MAX = ((longint'(1) <<< (DATA_W-1)) - 1) <<< SHIFT;
  localparam longint ST_MIN = -(longint'(1) <<< (DATA_W-1 + SHIFT));

  longint stateVal;
  longint inVal;
  always_comb begin
    stateVal = longint'($signed(filtState));
    inVal    = longint'($signed(sampleIn));
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (filtState == '0) && !filtValid);

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!sampleValid && !clrIn) |=> $stable(filtState));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    filtValid == $past(sampleValid && !clrIn && !rst));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clrIn |=> (filtState == '0) && !filtValid);

  // R7
  first_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !clrIn && filtState == '0) |=> stateVal == $past(inVal));

  // R8
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    (stateVal <= ST_MAX) && (stateVal >= ST_MIN));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !filtState[STATE_W-1] |-> !filtOut[DATA_W-1]);

endmodule

bind lpf_shift_iir lpf_shift_iir_chk #(.DATA_W(DATA_W), .SHIFT(SHIFT)) uChk (
  .clk         (clk),
  .rst         (rst),
  .clrIn       (clrIn),
  .sampleValid (sampleValid),
  .sampleIn    (sampleIn),
  .filtValid   (filtValid),
  .filtState   (filtState),
  .filtOut     (filtOut)
);

// File: tb/tb_lpf_shift_iir.sv
module tb_lpf_shift_iir;

  localparam int DATA_W = 12;
  localparam int SHIFT  = 4;
  localparam int CLK_PERIOD = 10;
  localparam int IN_MAX = (1 << (DATA_W-1)) - 1;
  localparam int IN_MIN = -(1 << (DATA_W-1));

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    clrIn = 1'b0;
  logic                    sampleValid = 1'b0;
  logic [DATA_W-1:0]       sampleIn = '0;
  logic                    filtValid;
  logic [DATA_W+SHIFT-1:0] filtState;
  logic [DATA_W-1:0]       filtOut;

  int nChecks = 0;
  int nFails  = 0;
  int mState  = 0;   // model state
  bit mValid  = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpf_shift_iir #(.DATA_W(DATA_W), .SHIFT(SHIFT)) dut (
    .clk(clk), .rst(rst), .clrIn(clrIn), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .filtValid(filtValid), .filtState(filtState),
    .filtOut(filtOut)
  );

  function automatic int nextState(int s, int x);
    int gap;
    gap = (x * (1 << SHIFT)) - s;
    return s + (gap >>> SHIFT);
  endfunction

  function automatic int roundedOut(int s);
    int r;
    r = (s + (1 << (SHIFT-1))) >>> SHIFT;
    if (r > IN_MAX) r = IN_MAX;
    return r;
  endfunction

  task automatic compare(string tag);
    int actState;
    int actOut;
    actState = $signed(filtState);
    actOut   = $signed(filtOut);
    nChecks++;
    if (actState != mState || actOut != roundedOut(mState) || filtValid != mValid) begin
      nFails++;
      $display("FAIL %s: state=%0d out=%0d valid=%0b expected state=%0d out=%0d valid=%0b",
               tag, actState, actOut, filtValid, mState, roundedOut(mState), mValid);
    end
  endtask

  // Drive one cycle at the falling edge, then check at the next falling edge.
  task automatic cycle(bit v, int x, bit c, string tag);
    sampleValid = v;
    sampleIn    = x[DATA_W-1:0];
    clrIn       = c;
    if (c) begin
      mState = 0; mValid = 1'b0;
    end else if (v) begin
      mState = nextState(mState, x); mValid = 1'b1;
    end else begin
      mValid = 1'b0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    int x;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mState = 0; mValid = 1'b0;
    compare("R1 reset state");

    // R7 step from zero, then decay toward it
    cycle(1, 1000, 0, "R7 first step");
    cycle(1, 1000, 0, "R2 second step");
    cycle(0, 0, 0, "R3 hold without valid");
    cycle(0, 1234, 0, "R3 ignore data without valid");
    // R5 clear together with a sample
    cycle(1, 777, 1, "R5 clear beats sample");
    cycle(1, -8, 0, "R6 half rounds up from -0.5");
    cycle(0, 0, 1, "R5 plain clear");
    cycle(1, 8, 0, "R6 half rounds up from +0.5");
    cycle(0, 0, 1, "R5 clear");
    for (int i = 0; i < 6; i++) cycle(1, IN_MIN, 0, "R2 negative extreme");
    for (int i = 0; i < 200; i++) cycle(1, IN_MAX, 0, "R8 positive extreme held");
    cycle(1, -1, 0, "R2 small negative step");

    // R1 reset mid-stream
    rst = 1'b1; sampleValid = 1'b1; sampleIn = 12'h123;
    @(negedge clk);
    rst = 1'b0; sampleValid = 1'b0;
    mState = 0; mValid = 1'b0;
    compare("R1 reset mid-stream");

    // Random stream with occasional collisions of clear and sample
    for (int i = 0; i < 2000; i++) begin
      bit v, c;
      v = ($urandom % 4) != 0;
      c = ($urandom % 25) == 0;
      x = int'($urandom % (1 << DATA_W)) + IN_MIN;
      cycle(v, x, c, (c && v) ? "R5 random collision" : "R2 R4 random stream");
    end
    finished = 1'b1;
  end

  initial begin
    int waited = 0;
    while (!finished && waited < 20000) begin
      @(posedge clk);
      waited++;
    end
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule